// File: doc/BRIEF.md
# Translation Context Resolver

This block is the front stage of a 64-bit address translation unit. Each request carries an effective address, an access class (load, store or instruction fetch) and the mode bits in force: hypervisor state, instruction relocation and data relocation. A hypervisor access with relocation off for its class skips translation. It comes back at once as a real address with every permission granted. Any other access takes its partition and process identifiers from the two top address bits. The mapping of those bits depends on hypervisor state, and two of the guest encodings are illegal.

For a legal context, the block looks up the partition-table entry for the chosen partition through a combinational side port. It checks that the entry is usable and that the process identifier falls inside the process table. It then reads the first doubleword of the 16-byte process-table entry over a valid/ready memory read port, with at most one read in flight. The result goes to the radix tree walker as a root directory base, a root directory size and a tree size, together with the effective address with its quadrant bits cleared. If the request cannot proceed, a segment or storage fault is reported instead. Every accepted request ends in exactly one single-cycle completion pulse.

Top module: `tcr_resolver`

## Requirements
- R1: After reset, `req_ready` is 1 and `done_valid` and `mem_req_valid` are 0.
- R2: With `mode_hv`=1 and relocation off for the class (`mode_ir`=0 for a fetch, `mode_dr`=0 for a load or store), the request completes with `done_real`=1, `done_addr` equal to the effective address with bits 63:60 cleared, `done_perm`=3'b111, and no memory read. Relocation off in guest state does not bypass. Access class encoding: 0 load, 1 store, 2 fetch.
- R3: In hypervisor state, quadrant q = ea[63:62] selects (partition, process) as follows: q=0 gives (0, PID register), q=1 gives (partition register, PID register), q=2 gives (partition register, 0), q=3 gives (0, 0).
- R4: In guest state, q=0 gives (partition register, PID register) and q=3 gives (partition register, 0).
- R5: In guest state, q=1 and q=2 raise a segment fault with no memory read. `done_fault_kind` is 1 (instruction segment) for a fetch, with `done_fault_addr`=0. It is 2 (data segment) otherwise, with `done_fault_addr` equal to the effective address.
- R6: A partition entry whose host-radix bit (`pt_host_radix`) is 0, or a lookup of partition 0 outside hypervisor state, raises a storage fault with cause 2 (bad configuration) and no memory read.
- R7: The process table spans 2^(`pt_proc_size`+12) bytes. If PID*16 is at or beyond that size, the block raises a storage fault with cause 1 (no entry) and makes no memory read. Configuration checks take priority over this bound check.
- R8: For a legal, in-bounds context, the block issues exactly one read at `pt_proc_base` + PID*16. It holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready`, and never has a read pending while `req_ready` is 1.
- R9: On success, the block reports `done_root_base` = {dw[55:8], 8'h00}, `done_root_size` = dw[4:0] and `done_tree_size` = dw[61:56] of the returned doubleword dw. It also reports `done_addr` = ea with bits 63:62 cleared, and the resolved partition and process.
- R10: Storage faults use `done_fault_kind` 3 for a fetch, with `done_fault_addr`=0. Loads and stores use kind 4, with `done_fault_addr` equal to the effective address and `done_fault_store`=1 only for a store.
- R11: Each accepted request produces exactly one single-cycle `done_valid` pulse carrying either a fault (`done_fault`=1, nonzero kind) or a result, never both. `req_ready` stays 0 from acceptance until after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_ea | input | 64 | Effective address |
| req_acc | input | 2 | Access class: 0 load, 1 store, 2 fetch |
| mode_hv | input | 1 | Hypervisor state |
| mode_ir | input | 1 | Instruction relocation enabled |
| mode_dr | input | 1 | Data relocation enabled |
| pid_reg | input | PID_W | Current process identifier register |
| lpid_reg | input | LPID_W | Current partition identifier register |
| pt_lpid | output | LPID_W | Partition whose table entry is looked up |
| pt_host_radix | input | 1 | Looked-up partition entry selects host radix |
| pt_proc_base | input | 64 | Process table base of that partition |
| pt_proc_size | input | 5 | Process table size field of that partition |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read doubleword |
| done_valid | output | 1 | Completion pulse |
| done_real | output | 1 | Translation bypassed (real mode) |
| done_fault | output | 1 | Completion is a fault |
| done_fault_kind | output | 3 | 1 instr segment, 2 data segment, 3 instr storage, 4 data storage |
| done_fault_cause | output | 2 | 1 no entry, 2 bad configuration |
| done_fault_store | output | 1 | Data storage fault on a store |
| done_fault_addr | output | 64 | Faulting address for data faults |
| done_perm | output | 3 | Granted read/write/execute in real mode |
| done_addr | output | 64 | Real address (bypass) or walker address |
| done_lpid | output | LPID_W | Resolved partition |
| done_pid | output | PID_W | Resolved process |
| done_root_base | output | 64 | Root directory base |
| done_root_size | output | 5 | Root directory size field |
| done_tree_size | output | 6 | Tree size field |

## Verification
The bound checker watches several properties on every cycle. It checks the completion pulse rule and that a fault and a result never appear together. It checks that the memory read request is held steady and that no read overlaps an idle state. It also checks that bypass results always grant all permissions with the top address nibble clear, that walker addresses never carry quadrant bits, and that fetch faults never report an address. The quadrant mapping, the configuration and bound faults, their priority, and the field extraction from the process-table doubleword all depend on the request and table contents. Only the scoreboard scenarios can show those, by comparing each completion against an independently computed expectation and counting memory reads.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

  localparam int ADDR_W        = 64;
  localparam int ENTRY_SHIFT   = 4;   // process-table entry is 16 bytes
  localparam int TBL_MIN_SHIFT = 12;  // table bytes = 2^(size field + 12)
  localparam int PRTS_W        = 5;
  localparam int RSZ_W         = 5;
  localparam int TSZ_W         = 6;
  localparam int RSZ_LSB       = 0;
  localparam int BASE_LSB      = 8;
  localparam int BASE_MSB      = 55;
  localparam int TSZ_LSB       = 56;
  localparam int REAL_CLR      = 4;   // top bits cleared in real mode

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    FK_NONE  = 3'd0,
    FK_ISEG  = 3'd1,
    FK_DSEG  = 3'd2,
    FK_ISTOR = 3'd3,
    FK_DSTOR = 3'd4
  } fkind_e;

  typedef enum logic [1:0] {
    FC_NONE   = 2'd0,
    FC_NOENT  = 2'd1,
    FC_BADCFG = 2'd2
  } fcause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RDREQ,
    ST_RDWAIT,
    ST_DONE
  } st_e;

  typedef struct packed {
    logic              real_m;
    logic              fault;
    fkind_e            kind;
    fcause_e           cause;
    logic              store;
    logic [2:0]        perm;
    logic [ADDR_W-1:0] faddr;
    logic [ADDR_W-1:0] addr;
  } outcome_t;

  function automatic outcome_t mk_fault(fkind_e k, fcause_e c, acc_e a,
                                        logic [ADDR_W-1:0] ea,
                                        logic [ADDR_W-1:0] walk);
    outcome_t o;
    o        = '0;
    o.fault  = 1'b1;
    o.kind   = k;
    o.cause  = c;
    o.store  = (k == FK_DSTOR) && (a == ACC_STORE);
    o.faddr  = (a == ACC_FETCH) ? '0 : ea;
    o.addr   = walk;
    return o;
  endfunction

endpackage

// File: rtl/tcr_rst_sync.sv
module tcr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/tcr_quad_decode.sv
module tcr_quad_decode #(
  parameter int PID_W  = 20,
  parameter int LPID_W = 12
) (
  input  logic [1:0]        quad,
  input  logic              hv,
  input  logic [PID_W-1:0]  pid_reg,
  input  logic [LPID_W-1:0] lpid_reg,
  output logic [LPID_W-1:0] lpid,
  output logic [PID_W-1:0]  pid,
  output logic              legal
);
  always_comb begin
    lpid  = '0;
    pid   = '0;
    legal = 1'b1;
    if (hv) begin
      case (quad)
        2'd0: pid = pid_reg;
        2'd1: begin lpid = lpid_reg; pid = pid_reg; end
        2'd2: lpid = lpid_reg;
        default: ;
      endcase
    end else begin
      case (quad)
        2'd0: begin lpid = lpid_reg; pid = pid_reg; end
        2'd3: lpid = lpid_reg;
        default: legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tcr_proc_bound.sv
module tcr_proc_bound
  import tcr_pkg::*;
#(
  parameter int PID_W = 20
) (
  input  logic [PID_W-1:0]  pid,
  input  logic [PRTS_W-1:0] size_field,
  output logic [ADDR_W-1:0] offset,
  output logic              over
);
  localparam int SH_W     = 7;
  localparam int PID_BIAS = TBL_MIN_SHIFT - ENTRY_SHIFT;

  logic [SH_W-1:0]  sh;
  logic [PID_W-1:0] hi;

  assign offset = ADDR_W'(pid) << ENTRY_SHIFT;
  // PID*16 >= 2^(s+12)  <=>  PID >= 2^(s+8)
  assign sh     = SH_W'(size_field) + SH_W'(PID_BIAS);
  assign hi     = pid >> sh;
  assign over   = |hi;
endmodule

// File: rtl/tcr_entry_unpack.sv
module tcr_entry_unpack
  import tcr_pkg::*;
(
  input  logic [ADDR_W-1:0] dw,
  output logic [ADDR_W-1:0] root_base,
  output logic [RSZ_W-1:0]  root_size,
  output logic [TSZ_W-1:0]  tree_size
);
  localparam int BASE_W = BASE_MSB - BASE_LSB + 1;

  logic unused_bits;

  assign root_base   = ADDR_W'({dw[BASE_MSB:BASE_LSB], {BASE_LSB{1'b0}}});
  assign root_size   = dw[RSZ_LSB +: RSZ_W];
  assign tree_size   = dw[TSZ_LSB +: TSZ_W];
  assign unused_bits = ^{dw[ADDR_W-1:TSZ_LSB+TSZ_W], dw[BASE_LSB-1:RSZ_LSB+RSZ_W],
                         BASE_W[0]};
endmodule

// File: rtl/tcr_resolver.sv
module tcr_resolver
  import tcr_pkg::*;
#(
  parameter int PID_W  = 20,
  parameter int LPID_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_ea,
  input  logic [1:0]        req_acc,
  input  logic              mode_hv,
  input  logic              mode_ir,
  input  logic              mode_dr,
  input  logic [PID_W-1:0]  pid_reg,
  input  logic [LPID_W-1:0] lpid_reg,
  output logic [LPID_W-1:0] pt_lpid,
  input  logic              pt_host_radix,
  input  logic [63:0]       pt_proc_base,
  input  logic [4:0]        pt_proc_size,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              done_valid,
  output logic              done_real,
  output logic              done_fault,
  output logic [2:0]        done_fault_kind,
  output logic [1:0]        done_fault_cause,
  output logic              done_fault_store,
  output logic [63:0]       done_fault_addr,
  output logic [2:0]        done_perm,
  output logic [63:0]       done_addr,
  output logic [LPID_W-1:0] done_lpid,
  output logic [PID_W-1:0]  done_pid,
  output logic [63:0]       done_root_base,
  output logic [4:0]        done_root_size,
  output logic [5:0]        done_tree_size
);
  localparam int AW      = ADDR_W;
  localparam int QUAD_HI = AW - 1;
  localparam int QUAD_LO = AW - 2;
  localparam logic [AW-1:0] REAL_MASK = {{REAL_CLR{1'b0}}, {(AW-REAL_CLR){1'b1}}};
  localparam logic [AW-1:0] WALK_MASK = {2'b00, {(AW-2){1'b1}}};

  // reset: asserted asynchronously, released on a clock edge
  logic rst_n_s;
  tcr_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  // state
  st_e               state_q, state_d;
  logic [AW-1:0]     ea_q;
  acc_e              acc_q;
  logic              hv_q;
  logic [LPID_W-1:0] lpid_q;
  logic [PID_W-1:0]  pid_q;
  logic              ctx_ld;
  outcome_t          res_q, res_d;
  logic              res_ld;
  logic [AW-1:0]     rd_addr_q, rd_addr_d;
  logic              rd_ld;
  logic [AW-1:0]     root_base_q;
  logic [RSZ_W-1:0]  root_size_q;
  logic [TSZ_W-1:0]  tree_q;
  logic              root_ld;

  // combinational helpers
  acc_e              req_acc_e;
  logic              accept;
  logic              real_req;
  logic              bad_cfg;
  logic [LPID_W-1:0] dec_lpid;
  logic [PID_W-1:0]  dec_pid;
  logic              dec_legal;
  logic [AW-1:0]     tbl_off;
  logic              tbl_over;
  logic [AW-1:0]     up_base;
  logic [RSZ_W-1:0]  up_rsize;
  logic [TSZ_W-1:0]  up_tsize;

  assign req_acc_e = acc_e'(req_acc);
  assign accept    = req_valid && (state_q == ST_IDLE);
  assign real_req  = mode_hv && ((req_acc_e == ACC_FETCH) ? !mode_ir : !mode_dr);
  assign bad_cfg   = !pt_host_radix || ((lpid_q == '0) && !hv_q);

  tcr_quad_decode #(.PID_W(PID_W), .LPID_W(LPID_W)) u_quad (
    .quad     (req_ea[QUAD_HI:QUAD_LO]),
    .hv       (mode_hv),
    .pid_reg  (pid_reg),
    .lpid_reg (lpid_reg),
    .lpid     (dec_lpid),
    .pid      (dec_pid),
    .legal    (dec_legal)
  );

  tcr_proc_bound #(.PID_W(PID_W)) u_bound (
    .pid        (pid_q),
    .size_field (pt_proc_size),
    .offset     (tbl_off),
    .over       (tbl_over)
  );

  tcr_entry_unpack u_unpack (
    .dw        (mem_rsp_data),
    .root_base (up_base),
    .root_size (up_rsize),
    .tree_size (up_tsize)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    res_d     = res_q;
    res_ld    = 1'b0;
    ctx_ld    = 1'b0;
    rd_ld     = 1'b0;
    rd_addr_d = rd_addr_q;
    root_ld   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          ctx_ld = 1'b1;
          res_ld = 1'b1;
          res_d  = '0;
          if (real_req) begin
            res_d.real_m = 1'b1;
            res_d.perm   = 3'b111;
            res_d.addr   = req_ea & REAL_MASK;
            state_d      = ST_DONE;
          end else if (!dec_legal) begin
            res_d   = mk_fault((req_acc_e == ACC_FETCH) ? FK_ISEG : FK_DSEG,
                               FC_NONE, req_acc_e, req_ea, req_ea & WALK_MASK);
            state_d = ST_DONE;
          end else begin
            res_d.addr = req_ea & WALK_MASK;
            state_d    = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (bad_cfg || tbl_over) begin
          res_ld  = 1'b1;
          res_d   = mk_fault((acc_q == ACC_FETCH) ? FK_ISTOR : FK_DSTOR,
                             bad_cfg ? FC_BADCFG : FC_NOENT,
                             acc_q, ea_q, res_q.addr);
          state_d = ST_DONE;
        end else begin
          rd_ld     = 1'b1;
          rd_addr_d = pt_proc_base + tbl_off;
          state_d   = ST_RDREQ;
        end
      end
      ST_RDREQ: begin
        if (mem_req_ready) state_d = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        if (mem_rsp_valid) begin
          root_ld = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control register
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  // datapath registers (no reset, explicit enables)
  always_ff @(posedge clk) begin
    if (ctx_ld) begin
      ea_q   <= req_ea;
      acc_q  <= req_acc_e;
      hv_q   <= mode_hv;
      lpid_q <= dec_lpid;
      pid_q  <= dec_pid;
    end
    if (res_ld) res_q <= res_d;
    if (rd_ld)  rd_addr_q <= rd_addr_d;
    if (root_ld) begin
      root_base_q <= up_base;
      root_size_q <= up_rsize;
      tree_q      <= up_tsize;
    end
  end

  // outputs
  assign req_ready        = (state_q == ST_IDLE);
  assign pt_lpid          = lpid_q;
  assign mem_req_valid    = (state_q == ST_RDREQ);
  assign mem_req_addr     = rd_addr_q;
  assign done_valid       = (state_q == ST_DONE);
  assign done_real        = res_q.real_m;
  assign done_fault       = res_q.fault;
  assign done_fault_kind  = res_q.kind;
  assign done_fault_cause = res_q.cause;
  assign done_fault_store = res_q.store;
  assign done_fault_addr  = res_q.faddr;
  assign done_perm        = res_q.perm;
  assign done_addr        = res_q.addr;
  assign done_lpid        = lpid_q;
  assign done_pid         = pid_q;
  assign done_root_base   = root_base_q;
  assign done_root_size   = root_size_q;
  assign done_tree_size   = tree_q;

endmodule

// File: rtl/tcr_resolver_chk.sv
module tcr_resolver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        done_valid,
  input logic        done_real,
  input logic        done_fault,
  input logic [2:0]  done_fault_kind,
  input logic [63:0] done_fault_addr,
  input logic [2:0]  done_perm,
  input logic [63:0] done_addr
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !(done_real && done_fault));

  assert_fault_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (done_fault_kind != 3'd0));

  assert_no_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_real_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_real) |-> (done_perm == 3'b111 && done_addr[63:60] == 4'h0));

  assert_walk_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_real && !done_fault) |-> (done_addr[63:62] == 2'b00));

  // R5 and R10: instruction-side faults carry no address
  assert_fetch_noaddr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault && (done_fault_kind == 3'd1 || done_fault_kind == 3'd3))
      |-> (done_fault_addr == 64'd0));
endmodule

bind tcr_resolver tcr_resolver_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_ready       (req_ready),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .done_valid      (done_valid),
  .done_real       (done_real),
  .done_fault      (done_fault),
  .done_fault_kind (done_fault_kind),
  .done_fault_addr (done_fault_addr),
  .done_perm       (done_perm),
  .done_addr       (done_addr)
);

// File: tb/tb_tcr_resolver.sv
`timescale 1ns/1ps
module tb_tcr_resolver;
  localparam int PID_W  = 20;
  localparam int LPID_W = 12;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [63:0]       req_ea;
  logic [1:0]        req_acc;
  logic              mode_hv, mode_ir, mode_dr;
  logic [PID_W-1:0]  pid_reg;
  logic [LPID_W-1:0] lpid_reg;
  logic [LPID_W-1:0] pt_lpid;
  logic              pt_host_radix;
  logic [63:0]       pt_proc_base;
  logic [4:0]        pt_proc_size;
  logic              mem_req_valid, mem_req_ready;
  logic [63:0]       mem_req_addr;
  logic              mem_rsp_valid;
  logic [63:0]       mem_rsp_data;
  logic              done_valid, done_real, done_fault, done_fault_store;
  logic [2:0]        done_fault_kind;
  logic [1:0]        done_fault_cause;
  logic [63:0]       done_fault_addr;
  logic [2:0]        done_perm;
  logic [63:0]       done_addr;
  logic [LPID_W-1:0] done_lpid;
  logic [PID_W-1:0]  done_pid;
  logic [63:0]       done_root_base;
  logic [4:0]        done_root_size;
  logic [5:0]        done_tree_size;

  tcr_resolver #(.PID_W(PID_W), .LPID_W(LPID_W)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // partition table model
  logic       tb_hr_zero, tb_hr_nz;
  logic [4:0] tb_prts;

  function automatic logic [63:0] pt_base(logic [LPID_W-1:0] lp);
    return 64'h0000_0040_0000_0000 + (64'(lp) << 20);
  endfunction

  assign pt_host_radix = (pt_lpid == '0) ? tb_hr_zero : tb_hr_nz;
  assign pt_proc_base  = pt_base(pt_lpid);
  assign pt_proc_size  = tb_prts;

  function automatic logic [63:0] mem_word(logic [63:0] a);
    return {2'b10, a[17:12] ^ 6'h09, a[55:8] ^ 48'h0000_1357_9BDF, 3'b110, a[8:4] ^ 5'h0D};
  endfunction

  // scoreboard
  typedef struct {
    logic              real_m;
    logic              fault;
    logic [2:0]        kind;
    logic [1:0]        cause;
    logic              store;
    logic [63:0]       faddr;
    logic [63:0]       addr;
    logic [LPID_W-1:0] lpid;
    logic [PID_W-1:0]  pid;
    logic [63:0]       rbase;
    logic [4:0]        rsize;
    logic [5:0]        tsize;
    int                reads;
    logic [63:0]       rd_addr;
    string             tag;
  } exp_t;

  exp_t q[$];
  int   n_chk, n_fail, exp_reads, rd_cnt;
  logic [63:0] last_addr;
  logic running;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: stall one cycle, accept, respond the next cycle
  initial begin
    int stall;
    logic [63:0] pend_addr;
    stall = 0; pend_addr = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    rd_cnt = 0; last_addr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        rd_cnt++;
        last_addr     = pend_addr;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(pend_addr);
      end else if (mem_req_valid) begin
        if (stall < 1) stall++;
        else begin
          stall = 0;
          mem_req_ready = 1'b1;
          pend_addr = mem_req_addr;
        end
      end
    end
  end

  // driver
  task automatic send(logic [63:0] ea, logic [1:0] acc, logic hv, logic ir, logic dr,
                      string tag);
    exp_t e;
    logic [LPID_W-1:0] lp;
    logic [PID_W-1:0]  pd;
    logic legal, bad, over;
    logic [63:0] w;
    e.real_m = 0; e.fault = 0; e.kind = 0; e.cause = 0; e.store = 0;
    e.faddr = 0; e.addr = 0; e.lpid = 0; e.pid = 0; e.rbase = 0;
    e.rsize = 0; e.tsize = 0; e.rd_addr = 0; e.tag = tag;
    if (hv && ((acc == 2'd2) ? !ir : !dr)) begin
      e.real_m = 1;
      e.addr   = ea & 64'h0FFF_FFFF_FFFF_FFFF;
    end else begin
      lp = '0; pd = '0; legal = 1;
      case ({hv, ea[63:62]})
        3'b100: pd = pid_reg;
        3'b101: begin lp = lpid_reg; pd = pid_reg; end
        3'b110: lp = lpid_reg;
        3'b111: ;
        3'b000: begin lp = lpid_reg; pd = pid_reg; end
        3'b011: lp = lpid_reg;
        default: legal = 0;
      endcase
      if (!legal) begin
        e.fault = 1;
        e.kind  = (acc == 2'd2) ? 3'd1 : 3'd2;
        e.faddr = (acc == 2'd2) ? 64'd0 : ea;
      end else begin
        bad  = !((lp == '0) ? tb_hr_zero : tb_hr_nz) || (lp == '0 && !hv);
        over = ((64'(pd)) * 64'd16) >= (64'd1 << (tb_prts + 12));
        if (bad || over) begin
          e.fault = 1;
          e.kind  = (acc == 2'd2) ? 3'd3 : 3'd4;
          e.cause = bad ? 2'd2 : 2'd1;
          e.store = (acc == 2'd1);
          e.faddr = (acc == 2'd2) ? 64'd0 : ea;
        end else begin
          exp_reads++;
          e.rd_addr = pt_base(lp) + 64'(pd) * 64'd16;
          w = mem_word(e.rd_addr);
          e.rbase = {8'h00, w[55:8], 8'h00};
          e.rsize = w[4:0];
          e.tsize = w[61:56];
          e.addr  = ea & 64'h3FFF_FFFF_FFFF_FFFF;
          e.lpid  = lp;
          e.pid   = pd;
        end
      end
    end
    e.reads = exp_reads;
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_ea = ea; req_acc = acc; mode_hv = hv; mode_ir = ir; mode_dr = dr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "busy after accept", 64'(req_ready), 64'd0);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (running && done_valid) begin
        if (q.size() == 0) begin
          chk("R11", "unexpected completion", 64'd1, 64'd0);
        end else begin
          e = q.pop_front();
          chk(e.tag, "real flag", 64'(done_real), 64'(e.real_m));
          chk(e.tag, "fault flag", 64'(done_fault), 64'(e.fault));
          chk(e.tag, "memory reads", 64'(rd_cnt), 64'(e.reads));
          if (e.real_m) begin
            chk(e.tag, "real addr", done_addr, e.addr);
            chk(e.tag, "perm", 64'(done_perm), 64'd7);
          end else if (e.fault) begin
            chk(e.tag, "fault kind", 64'(done_fault_kind), 64'(e.kind));
            chk(e.tag, "fault cause", 64'(done_fault_cause), 64'(e.cause));
            chk(e.tag, "store flag", 64'(done_fault_store), 64'(e.store));
            chk(e.tag, "fault addr", done_fault_addr, e.faddr);
          end else begin
            chk(e.tag, "walk addr", done_addr, e.addr);
            chk(e.tag, "partition", 64'(done_lpid), 64'(e.lpid));
            chk(e.tag, "process", 64'(done_pid), 64'(e.pid));
            chk(e.tag, "read addr", last_addr, e.rd_addr);
            chk(e.tag, "root base", done_root_base, e.rbase);
            chk(e.tag, "root size", 64'(done_root_size), 64'(e.rsize));
            chk(e.tag, "tree size", 64'(done_tree_size), 64'(e.tsize));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  // stimulus
  initial begin
    n_chk = 0; n_fail = 0; exp_reads = 0; running = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_ea = '0; req_acc = '0;
    mode_hv = 0; mode_ir = 0; mode_dr = 0;
    pid_reg = 20'h01234; lpid_reg = 12'h005;
    tb_hr_zero = 1; tb_hr_nz = 1; tb_prts = 5'd16;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    chk("R1", "done_valid", 64'(done_valid), 64'd0);
    chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    running = 1;

    // R2: bypass and non-bypass cases
    send(64'hF123_4567_89AB_CDE0, 2'd0, 1, 1, 0, "R2");
    send(64'hA000_0000_0000_1238, 2'd2, 1, 0, 1, "R2");
    send(64'h5555_0000_1111_2220, 2'd1, 1, 1, 0, "R2");
    send(64'h0000_0000_0012_3450, 2'd2, 1, 1, 0, "R2");
    send(64'h0000_0000_0000_7000, 2'd0, 0, 1, 0, "R2");
    // R3: hypervisor quadrants
    send(64'h0000_0000_0000_1000, 2'd0, 1, 1, 1, "R3");
    send(64'h4000_0000_0000_2000, 2'd0, 1, 1, 1, "R3");
    send(64'h8000_0000_0000_3000, 2'd1, 1, 1, 1, "R3");
    send(64'hC000_0000_0000_4000, 2'd2, 1, 1, 1, "R3");
    // R4: legal guest quadrants
    send(64'h0000_0000_0ABC_D000, 2'd0, 0, 1, 1, "R4");
    send(64'hC000_0000_0000_5008, 2'd1, 0, 1, 1, "R4");
    // R5: illegal guest quadrants
    send(64'h4000_0000_0000_6000, 2'd0, 0, 1, 1, "R5");
    send(64'h8000_0000_0000_6100, 2'd2, 0, 1, 1, "R5");
    send(64'h7000_0000_0000_6200, 2'd1, 0, 1, 1, "R5");
    drain();
    // R6: bad configuration
    lpid_reg = 12'h000;
    send(64'h0000_0000_0000_8000, 2'd0, 0, 1, 1, "R6");
    send(64'h0000_0000_0000_8100, 2'd0, 1, 1, 1, "R6");
    drain();
    lpid_reg = 12'h005; tb_hr_nz = 0;
    send(64'hC000_0000_0000_8200, 2'd2, 0, 1, 1, "R6");
    send(64'hC000_0000_0000_8300, 2'd1, 0, 1, 1, "R10");
    drain();
    // R7: process table bound
    tb_hr_nz = 1; tb_prts = 5'd0; pid_reg = 20'h00100;
    send(64'h0000_0000_0000_9000, 2'd1, 0, 1, 1, "R7");
    send(64'h0000_0000_0000_9100, 2'd2, 0, 1, 1, "R10");
    send(64'h8000_0000_0000_9200, 2'd0, 1, 1, 1, "R7");
    drain();
    tb_hr_nz = 0;
    send(64'h0000_0000_0000_9300, 2'd0, 0, 1, 1, "R7");
    drain();
    tb_hr_nz = 1; pid_reg = 20'h000FF;
    send(64'h0000_0000_0000_9400, 2'd0, 0, 1, 1, "R8");
    send(64'h4000_0000_0000_9500, 2'd1, 1, 1, 1, "R9");
    drain();
    chk("R11", "queue empty", 64'(q.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule